// File: doc/BRIEF.md
# Disk Identify Sequencer

This block runs one complete device-identification transaction on a parallel disk register interface (the eight-register task file of ATA/IDE) without processor help. On a start pulse it selects the master device and snapshots the status and error registers. It then polls status until the device is ready and idle, and refuses to continue if the device is already asking for data. Next it issues the identify command (0xEC), waits for the data request, and pulls 256 16-bit words into a local sector buffer. Last, it reads status and error once more and presents the result to the host.

The register interface is a single-cycle strobe bus. The sequencer drives address, read strobe, write strobe and write data from registers. During a read cycle the device side returns the selected register on `tf_rdata` in that same cycle, and the sequencer samples it on the closing clock edge. The host reads the captured words back through a one-cycle-latency port. That port can exchange the two bytes of a word, so text fields, which hold their first character in the upper byte, come out in reading order. Each wait loop has a cycle limit. A limit that runs out, or an unexpected status, ends the run with an error code.

Top module: `ide_identify_seq`

## Requirements
- R1: After reset, and whenever neither busy_o nor done_o is high, no read or write strobe is driven; done_o, err_o and err_code are 0 after reset.
- R2: A start pulse causes, in this order: a write of DEV_SEL (default 0xA0, master) to register 6; a read of status (register 7), latched on init_status; a read of error (register 1), latched on init_error.
- R3: Before the command, status is polled while busy (bit 7) is 1 or ready (bit 6) is 0. Value 0xEC is written to register 7 only after a status read shows busy 0, ready 1 and data request (bit 3) 0.
- R4: If the first idle-and-ready status read also shows data request 1, no command is written and the run ends with err_code 1, with that status on fin_status.
- R5: After the command, status is polled while busy is 1. Busy 0 with data request 1 and error (bit 0) 0 starts the transfer. Busy 0 with any other combination ends the run with err_code 2, with that status on fin_status.
- R6: The transfer is exactly 256 reads of register 0, one per cycle, and word k goes to buffer address k.
- R7: After the transfer, status and then error are read and latched on fin_status and fin_error, and done_o rises with err_code 0. Every run, aborted or not, ends with an error-register read latched on fin_error just before done_o rises. err_o is high only when done_o is high and err_code is nonzero.
- R8: The pre-command poll ends with err_code 3 if TIMEOUT consecutive status reads all keep it waiting. The post-command poll does the same with err_code 4. A deciding status on the last allowed read still wins. fin_status holds the last status read.
- R9: buf_data shows the word at buf_addr one cycle after the address is presented. With buf_swap high its upper and lower bytes are exchanged.
- R10: done_o stays high, with no bus strobe, until ack is pulsed. A start while done_o is high has no effect. After ack the block is idle and accepts a new start.
- R11: Read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an identify run (idle only) |
| ack | input | 1 | Acknowledge a finished run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, waiting for ack |
| err_o | output | 1 | Finished with an error |
| err_code | output | 3 | 0 ok, 1 early data request, 2 bad status, 3 ready timeout, 4 data-request timeout |
| tf_addr | output | 3 | Register address on the disk bus |
| tf_rd | output | 1 | Read strobe |
| tf_wr | output | 1 | Write strobe |
| tf_wdata | output | 16 | Write data |
| tf_rdata | input | 16 | Read data, valid in the strobe cycle |
| init_status | output | 8 | Status read at the start |
| init_error | output | 8 | Error register read at the start |
| fin_status | output | 8 | Status at the end or at the abort |
| fin_error | output | 8 | Error register read at the end |
| buf_addr | input | 8 | Sector buffer read address |
| buf_swap | input | 1 | Exchange bytes of the returned word |
| buf_data | output | 16 | Sector buffer read data |

## Verification
The hardest situations to reach are the timeout edges: a device that gives a deciding status exactly on the last allowed poll, and one that answers one poll too late. The bench device model counts its own status reads and switches its answer after a chosen number of them. Directed runs place that number on both sides of the limit, in both the pre-command and the post-command poll. Random runs then mix device behaviours, delays, error-register values and data patterns, and every captured word is read back with a random byte-swap setting.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

  // register addresses decoded by the device
  localparam logic [2:0] REG_DATA  = 3'd0;
  localparam logic [2:0] REG_ERR   = 3'd1;
  localparam logic [2:0] REG_DEV   = 3'd6;
  localparam logic [2:0] REG_STCMD = 3'd7;

  // status bit positions
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] CMD_IDENTIFY = 8'hEC;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_ST0, S_ER0, S_POLL, S_CMD,
    S_WAITQ, S_XFER, S_ST1, S_ER1, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    E_NONE        = 3'd0,
    E_EARLY_DRQ   = 3'd1,
    E_BAD_STATUS  = 3'd2,
    E_RDY_TIMEOUT = 3'd3,
    E_DRQ_TIMEOUT = 3'd4
  } seq_err_t;

  typedef enum logic [1:0] {
    V_WAIT, V_GO, V_FAULT
  } verdict_t;

endpackage

// File: rtl/ide_status_judge.sv
module ide_status_judge
  import ide_seq_pkg::*;
(
  input  logic [7:0] status,
  input  logic       after_cmd,
  output verdict_t   verdict
);

  logic bsy, drdy, drq, erb;
  assign bsy  = status[ST_BSY];
  assign drdy = status[ST_DRDY];
  assign drq  = status[ST_DRQ];
  assign erb  = status[ST_ERR];

  always_comb begin
    if (!after_cmd) begin
      if (bsy || !drdy) verdict = V_WAIT;
      else if (drq)     verdict = V_FAULT;
      else              verdict = V_GO;
    end else begin
      if (bsy)              verdict = V_WAIT;
      else if (drq && !erb) verdict = V_GO;
      else                  verdict = V_FAULT;
    end
  end

endmodule

// File: rtl/ide_wait_timer.sv
module ide_wait_timer #(
  parameter int TIMEOUT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);

  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                      cnt <= '0;
    else if (cnt != CW'(TIMEOUT - 1))     cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/ide_sector_buf.sv
module ide_sector_buf #(
  parameter int WORDS = 256,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  input  logic                     rswap,
  output logic [DW-1:0]            rdata
);

  localparam int HW = DW / 2;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] q;
  logic          swap_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    q      <= mem[raddr];
    swap_q <= rswap;
  end

  assign rdata = swap_q ? {q[HW-1:0], q[DW-1:HW]} : q;

endmodule

// File: rtl/ide_identify_seq.sv
module ide_identify_seq
  import ide_seq_pkg::*;
#(
  parameter int         WORDS   = 256,
  parameter int         TIMEOUT = 100000,
  parameter logic [7:0] DEV_SEL = 8'hA0,
  localparam int        AW      = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ack,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    err_code,
  output logic [2:0]    tf_addr,
  output logic          tf_rd,
  output logic          tf_wr,
  output logic [15:0]   tf_wdata,
  input  logic [15:0]   tf_rdata,
  output logic [7:0]    init_status,
  output logic [7:0]    init_error,
  output logic [7:0]    fin_status,
  output logic [7:0]    fin_error,
  input  logic [AW-1:0] buf_addr,
  input  logic          buf_swap,
  output logic [15:0]   buf_data
);

  seq_state_t st, nxt;
  seq_err_t   err_q, abort_code;
  logic       abort;
  verdict_t   verdict;
  logic       wait_run, wait_last;
  logic [AW-1:0] wcnt;

  ide_status_judge u_judge (
    .status    (tf_rdata[7:0]),
    .after_cmd (st == S_WAITQ),
    .verdict   (verdict)
  );

  assign wait_run = (st == S_POLL) || (st == S_WAITQ);

  ide_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (wait_run),
    .last (wait_last)
  );

  ide_sector_buf #(.WORDS(WORDS), .DW(16)) u_buf (
    .clk   (clk),
    .we    (st == S_XFER),
    .waddr (wcnt),
    .wdata (tf_rdata),
    .raddr (buf_addr),
    .rswap (buf_swap),
    .rdata (buf_data)
  );

  // next state and abort decision
  always_comb begin
    nxt        = st;
    abort      = 1'b0;
    abort_code = E_NONE;
    unique case (st)
      S_IDLE:  if (start) nxt = S_SEL;
      S_SEL:   nxt = S_ST0;
      S_ST0:   nxt = S_ER0;
      S_ER0:   nxt = S_POLL;
      S_POLL: begin
        if (verdict == V_GO) nxt = S_CMD;
        else if (verdict == V_FAULT) begin
          abort = 1'b1; abort_code = E_EARLY_DRQ;
        end else if (wait_last) begin
          abort = 1'b1; abort_code = E_RDY_TIMEOUT;
        end
      end
      S_CMD:   nxt = S_WAITQ;
      S_WAITQ: begin
        if (verdict == V_GO) nxt = S_XFER;
        else if (verdict == V_FAULT) begin
          abort = 1'b1; abort_code = E_BAD_STATUS;
        end else if (wait_last) begin
          abort = 1'b1; abort_code = E_DRQ_TIMEOUT;
        end
      end
      S_XFER:  if (wcnt == AW'(WORDS - 1)) nxt = S_ST1;
      S_ST1:   nxt = S_ER1;
      S_ER1:   nxt = S_DONE;
      S_DONE:  if (ack) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (abort) nxt = S_ER1;
  end

  // bus strobes decoded from the next state so they leave a register
  logic       n_rd, n_wr;
  logic [2:0] n_addr;
  logic [7:0] n_wdata;

  always_comb begin
    n_rd    = 1'b0;
    n_wr    = 1'b0;
    n_addr  = REG_DATA;
    n_wdata = 8'h00;
    unique case (nxt)
      S_SEL:   begin n_wr = 1'b1; n_addr = REG_DEV;   n_wdata = DEV_SEL;      end
      S_CMD:   begin n_wr = 1'b1; n_addr = REG_STCMD; n_wdata = CMD_IDENTIFY; end
      S_ST0, S_POLL, S_WAITQ, S_ST1:
               begin n_rd = 1'b1; n_addr = REG_STCMD; end
      S_ER0, S_ER1:
               begin n_rd = 1'b1; n_addr = REG_ERR;   end
      S_XFER:  begin n_rd = 1'b1; n_addr = REG_DATA;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      tf_rd    <= 1'b0;
      tf_wr    <= 1'b0;
      tf_addr  <= REG_DATA;
      tf_wdata <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      err_q    <= E_NONE;
    end else begin
      st       <= nxt;
      tf_rd    <= n_rd;
      tf_wr    <= n_wr;
      tf_addr  <= n_addr;
      tf_wdata <= {8'h00, n_wdata};
      busy_o   <= (nxt != S_IDLE) && (nxt != S_DONE);
      done_o   <= (nxt == S_DONE);
      if (st == S_IDLE && start) err_q <= E_NONE;
      else if (abort)            err_q <= abort_code;
      err_o    <= (nxt == S_DONE) && (err_q != E_NONE);
    end
  end

  assign err_code = err_q;

  // captured register values
  always_ff @(posedge clk) begin
    if (rst) begin
      init_status <= '0;
      init_error  <= '0;
      fin_status  <= '0;
      fin_error   <= '0;
    end else begin
      if (st == S_ST0)          init_status <= tf_rdata[7:0];
      if (st == S_ER0)          init_error  <= tf_rdata[7:0];
      if (st == S_ST1 || abort) fin_status  <= tf_rdata[7:0];
      if (st == S_ER1)          fin_error   <= tf_rdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st != S_XFER) wcnt <= '0;
    else                     wcnt <= wcnt + 1'b1;
  end

endmodule

// File: rtl/ide_identify_seq_chk.sv
module ide_identify_seq_chk #(
  parameter logic [7:0] DEV_SEL = 8'hA0
) (
  input logic        clk,
  input logic        rst,
  input logic        ack,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  tf_addr,
  input logic        tf_rd,
  input logic        tf_wr,
  input logic [15:0] tf_wdata
);

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(tf_rd && tf_wr));

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o) |-> (!tf_rd && !tf_wr));

  assert_select_master_R2: assert property (@(posedge clk) disable iff (rst)
    (tf_wr && tf_addr == 3'd6) |-> (tf_wdata[7:0] == DEV_SEL));

  assert_command_code_R3: assert property (@(posedge clk) disable iff (rst)
    (tf_wr && tf_addr == 3'd7) |-> (tf_wdata[7:0] == 8'hEC));

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ack) |=> done_o);

  assert_done_no_bus_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!tf_rd && !tf_wr));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_last_read_error_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(tf_rd && tf_addr == 3'd1));

endmodule

bind ide_identify_seq ide_identify_seq_chk #(.DEV_SEL(DEV_SEL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .tf_addr  (tf_addr),
  .tf_rd    (tf_rd),
  .tf_wr    (tf_wr),
  .tf_wdata (tf_wdata)
);

// File: tb/tb_ide_identify_seq.sv
`timescale 1ns/1ps
module tb_ide_identify_seq;

  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, ack = 1'b0;
  logic busy_o, done_o, err_o;
  logic [2:0] err_code, tf_addr;
  logic tf_rd, tf_wr;
  logic [15:0] tf_wdata, tf_rdata;
  logic [7:0] init_status, init_error, fin_status, fin_error;
  logic [7:0] buf_addr = '0;
  logic buf_swap = 1'b0;
  logic [15:0] buf_data;

  always #2 clk = ~clk;

  ide_identify_seq #(.WORDS(256), .TIMEOUT(TO), .DEV_SEL(8'hA0)) dut (
    .clk(clk), .rst(rst), .start(start), .ack(ack),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code(err_code),
    .tf_addr(tf_addr), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .init_status(init_status), .init_error(init_error),
    .fin_status(fin_status), .fin_error(fin_error),
    .buf_addr(buf_addr), .buf_swap(buf_swap), .buf_data(buf_data)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: 0 good, 1 early data request, 2 error status, 3 never ready, 4 never data
  int mode = 0, rdy_delay = 0, cmd_delay = 0;
  logic [7:0]  errv = 8'h00;
  logic [15:0] seed16 = 16'h0;
  logic mdl_clr = 1'b0;
  logic post;
  int pre_cnt, post_cnt, widx, n_ops, n_dev, n_cmd, n_data;
  logic [7:0] dev_val;
  logic first_ok;

  function automatic logic [15:0] wordf(input int i, input logic [15:0] s);
    logic [7:0] b;
    b = 8'(i);
    return 16'(i * 40503) ^ s ^ {b, ~b};
  endfunction

  function automatic logic [7:0] stat_now();
    if (!post) begin
      if (mode == 3 || pre_cnt < rdy_delay) return 8'h80;
      return (mode == 1) ? 8'h48 : 8'h40;
    end
    if (mode == 4 || post_cnt < cmd_delay) return 8'h80;
    if (mode == 2) return 8'h41;
    return (widx < 256) ? 8'h48 : 8'h50;
  endfunction

  always_comb begin
    case (tf_addr)
      3'd7:    tf_rdata = {8'h00, stat_now()};
      3'd1:    tf_rdata = {8'h00, errv};
      3'd0:    tf_rdata = wordf(widx, seed16);
      default: tf_rdata = 16'h0;
    endcase
  end

  always @(posedge clk) begin
    if (mdl_clr) begin
      post <= 1'b0; pre_cnt <= 0; post_cnt <= 0; widx <= 0;
      n_ops <= 0; n_dev <= 0; n_cmd <= 0; n_data <= 0;
      dev_val <= 8'h00; first_ok <= 1'b0;
    end else begin
      if (tf_rd || tf_wr) begin
        n_ops <= n_ops + 1;
        if (n_ops == 0) first_ok <= tf_wr && tf_addr == 3'd6;
      end
      if (tf_wr && tf_addr == 3'd6) begin n_dev <= n_dev + 1; dev_val <= tf_wdata[7:0]; end
      if (tf_wr && tf_addr == 3'd7) begin n_cmd <= n_cmd + 1; post <= 1'b1; end
      if (tf_rd && tf_addr == 3'd7) begin
        if (!post) pre_cnt <= pre_cnt + 1;
        else       post_cnt <= post_cnt + 1;
      end
      if (tf_rd && tf_addr == 3'd0) begin widx <= widx + 1; n_data <= n_data + 1; end
    end
  end

  task automatic exp_result(output int code, output logic [7:0] fs);
    if (mode == 3 || rdy_delay > TO)         begin code = 3; fs = 8'h80; end
    else if (mode == 1)                      begin code = 1; fs = 8'h48; end
    else if (mode == 4 || cmd_delay > TO - 1) begin code = 4; fs = 8'h80; end
    else if (mode == 2)                      begin code = 2; fs = 8'h41; end
    else                                     begin code = 0; fs = 8'h50; end
  endtask

  task automatic run_case(input int m, input int rd, input int cd);
    int code; logic [7:0] fs, is; int guard; int ops_before;
    mode = m; rdy_delay = rd; cmd_delay = cd;
    errv = 8'($urandom); seed16 = 16'($urandom);
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
    chk(done_o, "R7 run reaches done", done_o, 1);
    exp_result(code, fs);
    is = (mode == 3 || rdy_delay > 0) ? 8'h80 : ((mode == 1) ? 8'h48 : 8'h40);
    chk(first_ok && n_dev == 1 && dev_val == 8'hA0, "R2 first op selects master", dev_val, 8'hA0);
    chk(init_status == is, "R2 init_status", init_status, is);
    chk(init_error == errv, "R2 init_error", init_error, errv);
    chk(int'(err_code) == code, "R4 R5 R8 err_code", err_code, code);
    chk(err_o == (code != 0), "R7 err_o", err_o, code != 0);
    chk(fin_status == fs, "R7 R8 fin_status", fin_status, fs);
    chk(fin_error == errv, "R7 fin_error", fin_error, errv);
    chk(n_cmd == ((code == 0 || code == 2 || code == 4) ? 1 : 0), "R3 R4 command count", n_cmd,
        (code == 0 || code == 2 || code == 4) ? 1 : 0);
    chk(n_data == ((code == 0) ? 256 : 0), "R6 data read count", n_data, (code == 0) ? 256 : 0);
    if (code == 0) begin
      for (int k = 0; k < 256; k++) begin
        logic [15:0] w;
        logic sw;
        sw = 1'($urandom);
        buf_addr = 8'(k); buf_swap = sw;
        @(negedge clk);
        w = wordf(k, seed16);
        if (sw) w = {w[7:0], w[15:8]};
        chk(buf_data == w, "R6 R9 buffer word", buf_data, w);
      end
    end
    // start while done is ignored
    ops_before = n_ops;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_o && !busy_o && n_ops == ops_before, "R10 start ignored while done", n_ops, ops_before);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(!done_o && !busy_o && !err_o, "R10 idle after ack", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    mdl_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; mdl_clr = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done_o && !busy_o && !err_o && err_code == 3'd0, "R1 reset outputs", done_o, 0);
    chk(!tf_rd && !tf_wr, "R1 no strobes after reset", tf_rd, 0);
    // directed corner cases
    run_case(0, 0, 0);        // R3 immediate ready, R6 transfer
    run_case(1, 5, 0);        // R4 early data request
    run_case(2, 3, 7);        // R5 error status after command
    run_case(0, TO, TO - 1);  // R8 decision on the last allowed reads
    run_case(0, TO + 1, 0);   // R8 ready timeout by one read
    run_case(0, 2, TO);       // R8 data-request timeout by one read
    run_case(3, 0, 0);        // R8 never ready
    run_case(4, 1, 0);        // R8 never requests data
    // random mix
    for (int i = 0; i < 12; i++)
      run_case($urandom_range(0, 4), $urandom_range(0, TO + 4), $urandom_range(0, TO + 3));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule